// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and one asynchronous static RAM. The host presents a single-word read or write request. The controller then produces the RAM's active-low chip-select, output-enable and write-enable strobes, holds the address, and drives or releases the data bus. It returns read data together with a one-cycle completion pulse. The RAM has no clock, so every phase of a cycle is timed by counting controller clocks.

Each RAM timing minimum is a parameter in nanoseconds, and the clock period is a parameter too. At elaboration the controller turns each minimum into a whole number of clocks. The rule is the ceiling of value over period, with a floor of one clock. The address-setup and write-recovery phases are left out when their minimum is zero. Writes are strobed by write enable, and chip select stays low from the start to the end of the cycle. Output enable stays high for the whole of a write, so the RAM never drives the bus while the controller does. The data bus is split at the pad boundary into an output value, an output enable and an input value.

Defaults describe a slow 120 ns part on a 5 ns clock. One read then takes 24 clocks, and one write takes 24 clocks, with a 21-clock write strobe.

Top module: `sram_ctrl`

## Requirements
- R1: During reset and whenever no access is in progress, `sram_ce_n`, `sram_oe_n` and `sram_we_n` are 1, `sram_dq_oe` is 0 and `done` is 0.
- R2: `sram_we_n` is 0 only in cycles where `sram_ce_n` is 0.
- R3: `sram_oe_n` is 0 only during reads and is never 0 together with `sram_we_n`; for the whole of a write `sram_oe_n` stays 1.
- R4: `sram_dq_oe` is 1 only while `sram_oe_n` is 1, and it stays 0 for the whole of a read.
- R5: A read holds `sram_ce_n` and `sram_oe_n` low for max(ceil(tRC), ceil(max(tAA, tACS))) clocks, which is 24 at the defaults and 5 for a 25 ns part. `rd_data` is captured at the clock edge that comes ceil(max(tAA, tACS)) clocks after chip select fell. It then holds until the next read captures.
- R6: The write strobe lasts WP = max(ceil(tWP), ceil(tDW), ceil(tCW) - AS, ceil(tAW) - AS) clocks, with a floor of 1. Here AS = ceil(tAS), or 0 when tAS is 0. The strobe falls AS clocks after chip select falls, which is the same edge when AS is 0.
- R7: `sram_dq_oe` is 1 from the edge at which the strobe falls until ceil(tDH) clocks (at least one) after it rises. While it is 1, `sram_dq_o` holds the request's `req_wdata`, and that word is what a later read of the address returns.
- R8: A write holds `sram_ce_n` low for max(AS + WP + max(ceil(tWR) or 0, ceil(tDH)), ceil(tWC)) clocks. That is 24 at the defaults, and 7 for the 25 ns part with tAS = 7 ns and tWR = 8 ns.
- R9: `done` is high for exactly one cycle per accepted request, in the cycle after `sram_ce_n` returns high.
- R10: `req` is ignored while an access is in progress. A `req` that is held high in the cycle where `done` is high is accepted at the next edge.
- R11: While `sram_ce_n` is 0, `sram_addr` holds the address of the request that was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Access request, sampled only when idle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write word |
| rd_data | output | DW | Last word read |
| done | output | 1 | One-cycle completion pulse |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_addr | output | AW | RAM address |
| sram_dq_o | output | DW | Data value driven toward the RAM |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_i | input | DW | Data value seen on the pads |

## Verification
Completion of one access and acceptance of the next can fall in the same cycle. The `done` pulse is raised in the cycle where the controller has just returned to idle, and a `req` that is still high then is taken at the next edge. The bench provokes this by holding `req` high through a write, with a read of the same address queued behind it. It then judges the result by three things: exactly two completion pulses, a chip-select low count equal to the write length plus the read length, and the read returning the word just written. A behavioural RAM in the bench hides read data until just before the access time has elapsed, so a capture made one clock early returns a marker word instead of the stored data.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } sram_st_e;

   // whole clocks covering a minimum, never fewer than one
   function automatic int cyc_min1(input int ns, input int clk_ns);
      if (ns <= 0) return 1;
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   // optional phase: zero clocks when the minimum is zero
   function automatic int cyc_opt(input int ns, input int clk_ns);
      if (ns <= 0) return 0;
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // remaining clocks after a phase already spent, floor of one
   function automatic int rest_min1(input int need, input int spent);
      return (need > spent) ? need - spent : 1;
   endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
`timescale 1ns/1ps
module sram_ctrl_seq
   import sram_ctrl_pkg::*;
#(
   parameter int N_RD  = 24,
   parameter int W_TOT = 24,
   parameter int CW    = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          req_we,
   output logic          accept,
   output sram_st_e      st_q,
   output logic [CW-1:0] cnt_q,
   output sram_st_e      nxt_st,
   output logic [CW-1:0] nxt_cnt,
   output logic          done
);

   localparam logic [CW-1:0] LAST_RD = CW'(N_RD);
   localparam logic [CW-1:0] LAST_WR = CW'(W_TOT);

   logic fin;

   assign fin = ((st_q == ST_READ)  && (cnt_q == LAST_RD)) ||
                ((st_q == ST_WRITE) && (cnt_q == LAST_WR));

   always_comb begin
      accept  = 1'b0;
      nxt_st  = st_q;
      nxt_cnt = cnt_q;
      if (st_q == ST_IDLE) begin
         if (req) begin
            accept  = 1'b1;
            nxt_st  = req_we ? ST_WRITE : ST_READ;
            nxt_cnt = CW'(1);
         end
      end else if (fin) begin
         nxt_st  = ST_IDLE;
         nxt_cnt = '0;
      end else begin
         nxt_cnt = cnt_q + CW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         st_q  <= nxt_st;
         cnt_q <= nxt_cnt;
         done  <= fin;
      end
   end

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_busy_ignores_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && !fin) |=> (cnt_q == $past(cnt_q) + CW'(1)));

   assert_done_after_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (st_q == ST_IDLE));

endmodule

// File: rtl/sram_ctrl_pins.sv
`timescale 1ns/1ps
module sram_ctrl_pins
   import sram_ctrl_pkg::*;
#(
   parameter int CW   = 5,
   parameter int W_AS = 0,
   parameter int W_P  = 21,
   parameter int W_DH = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  sram_st_e      nxt_st,
   input  logic [CW-1:0] nxt_cnt,
   output logic          ce_n,
   output logic          oe_n,
   output logic          we_n,
   output logic          dq_oe
);

   localparam logic [CW-1:0] STROBE_ON  = CW'(W_AS + 1);
   localparam logic [CW-1:0] STROBE_OFF = CW'(W_AS + W_P);
   localparam logic [CW-1:0] DRIVE_OFF  = CW'(W_AS + W_P + W_DH);

   logic in_strobe;
   logic in_drive;

   generate
      if (W_AS == 0) begin : g_no_setup
         // strobe starts on the same edge as chip select
         assign in_strobe = (nxt_cnt <= STROBE_OFF);
         assign in_drive  = (nxt_cnt <= DRIVE_OFF);
      end else begin : g_setup
         assign in_strobe = (nxt_cnt >= STROBE_ON) && (nxt_cnt <= STROBE_OFF);
         assign in_drive  = (nxt_cnt >= STROBE_ON) && (nxt_cnt <= DRIVE_OFF);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ce_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         ce_n  <= (nxt_st == ST_IDLE);
         oe_n  <= (nxt_st != ST_READ);
         we_n  <= !((nxt_st == ST_WRITE) && in_strobe);
         dq_oe <= (nxt_st == ST_WRITE) && in_drive;
      end
   end

   assert_strobe_inside_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> !ce_n);

   assert_oe_we_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(!oe_n && !we_n));

   assert_no_drive_when_ram_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> oe_n);

   assert_data_held_past_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> dq_oe);

endmodule

// File: rtl/sram_ctrl_data.sv
`timescale 1ns/1ps
module sram_ctrl_data
   import sram_ctrl_pkg::*;
#(
   parameter int AW    = 8,
   parameter int DW    = 8,
   parameter int CW    = 5,
   parameter int N_ACC = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  sram_st_e      st_q,
   input  logic [CW-1:0] cnt_q,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] dq_i,
   output logic [AW-1:0] sram_addr,
   output logic [DW-1:0] dq_o,
   output logic [DW-1:0] rd_data
);

   localparam logic [CW-1:0] CAPTURE_AT = CW'(N_ACC);

   logic capture;

   assign capture = (st_q == ST_READ) && (cnt_q == CAPTURE_AT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sram_addr <= '0;
         dq_o      <= '0;
         rd_data   <= '0;
      end else begin
         if (accept) begin
            sram_addr <= req_addr;
            dq_o      <= req_wdata;
         end
         if (capture) rd_data <= dq_i;
      end
   end

   assert_rdata_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_READ) |=> $stable(rd_data));

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int AW       = 8,
   parameter int DW       = 8,
   parameter int T_CLK_NS = 5,
   parameter int T_RC     = 120,
   parameter int T_AA     = 120,
   parameter int T_ACS    = 120,
   parameter int T_WC     = 120,
   parameter int T_CW     = 70,
   parameter int T_AW     = 105,
   parameter int T_AS     = 0,
   parameter int T_WP     = 70,
   parameter int T_WR     = 0,
   parameter int T_DW     = 35,
   parameter int T_DH     = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req,
   input  logic          req_we,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic [DW-1:0] rd_data,
   output logic          done,
   output logic          sram_ce_n,
   output logic          sram_oe_n,
   output logic          sram_we_n,
   output logic [AW-1:0] sram_addr,
   output logic [DW-1:0] sram_dq_o,
   output logic          sram_dq_oe,
   input  logic [DW-1:0] sram_dq_i
);

   // read phases
   localparam int N_ACC  = cyc_min1(imax(T_AA, T_ACS), T_CLK_NS);
   localparam int N_RD   = imax(N_ACC, cyc_min1(T_RC, T_CLK_NS));
   // write phases
   localparam int W_AS   = cyc_opt(T_AS, T_CLK_NS);
   localparam int W_P    = imax(imax(cyc_min1(T_WP, T_CLK_NS), cyc_min1(T_DW, T_CLK_NS)),
                                imax(rest_min1(cyc_min1(T_CW, T_CLK_NS), W_AS),
                                     rest_min1(cyc_min1(T_AW, T_CLK_NS), W_AS)));
   localparam int W_DH   = cyc_min1(T_DH, T_CLK_NS);
   localparam int W_POST = imax(cyc_opt(T_WR, T_CLK_NS), W_DH);
   localparam int W_TOT  = imax(W_AS + W_P + W_POST, cyc_min1(T_WC, T_CLK_NS));
   localparam int CW     = $clog2(imax(N_RD, W_TOT) + 1);

   generate
      if (T_CLK_NS < 1) begin : g_bad_clk
         $error("sram_ctrl: clock period must be at least 1 ns");
      end
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("sram_ctrl: address and data widths must be positive");
      end
   endgenerate

   logic          accept;
   sram_st_e      st_q;
   sram_st_e      nxt_st;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] nxt_cnt;

   sram_ctrl_seq #(
      .N_RD  (N_RD),
      .W_TOT (W_TOT),
      .CW    (CW)
   ) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .req_we  (req_we),
      .accept  (accept),
      .st_q    (st_q),
      .cnt_q   (cnt_q),
      .nxt_st  (nxt_st),
      .nxt_cnt (nxt_cnt),
      .done    (done)
   );

   sram_ctrl_pins #(
      .CW   (CW),
      .W_AS (W_AS),
      .W_P  (W_P),
      .W_DH (W_DH)
   ) i_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .nxt_st  (nxt_st),
      .nxt_cnt (nxt_cnt),
      .ce_n    (sram_ce_n),
      .oe_n    (sram_oe_n),
      .we_n    (sram_we_n),
      .dq_oe   (sram_dq_oe)
   );

   sram_ctrl_data #(
      .AW    (AW),
      .DW    (DW),
      .CW    (CW),
      .N_ACC (N_ACC)
   ) i_data (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .st_q      (st_q),
      .cnt_q     (cnt_q),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_i      (sram_dq_i),
      .sram_addr (sram_addr),
      .dq_o      (sram_dq_o),
      .rd_data   (rd_data)
   );

   assert_addr_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

   assert_wdata_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_o));

   assert_idle_on_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe));

endmodule

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;

   // index 0: slow part on defaults; index 1: 25 ns part with setup and recovery
   // expected clocks at 5 ns, from the rules in the requirements
   localparam int EXP_RD [2] = '{24, 5};   // R5
   localparam int EXP_WT [2] = '{24, 7};   // R8
   localparam int EXP_WP [2] = '{21, 3};   // R6
   localparam int EXP_AS [2] = '{0, 2};    // R6
   localparam int EXP_DRV[2] = '{22, 4};   // R7: WP + 1
   localparam int ACC_NS [2] = '{120, 25};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic       req   [2] = '{1'b0, 1'b0};
   logic       wen   [2] = '{1'b0, 1'b0};
   logic [7:0] ha    [2] = '{8'h00, 8'h00};
   logic [7:0] hw    [2] = '{8'h00, 8'h00};
   logic [7:0] rd    [2];
   logic       done  [2];
   logic       ce_n  [2];
   logic       oe_n  [2];
   logic       we_n  [2];
   logic [7:0] sa    [2];
   logic [7:0] dq_o  [2];
   logic       dq_oe [2];
   logic [7:0] dq_i  [2];

   sram_ctrl i_sram_ctrl (
      .clk(clk), .rst_n(rst_n), .req(req[0]), .req_we(wen[0]), .req_addr(ha[0]),
      .req_wdata(hw[0]), .rd_data(rd[0]), .done(done[0]), .sram_ce_n(ce_n[0]),
      .sram_oe_n(oe_n[0]), .sram_we_n(we_n[0]), .sram_addr(sa[0]), .sram_dq_o(dq_o[0]),
      .sram_dq_oe(dq_oe[0]), .sram_dq_i(dq_i[0])
   );

   sram_ctrl #(
      .T_RC(25), .T_AA(25), .T_ACS(25), .T_WC(25), .T_CW(15), .T_AW(15),
      .T_AS(7), .T_WP(15), .T_WR(8), .T_DW(12), .T_DH(0)
   ) i_sram_ctrl_fast (
      .clk(clk), .rst_n(rst_n), .req(req[1]), .req_we(wen[1]), .req_addr(ha[1]),
      .req_wdata(hw[1]), .rd_data(rd[1]), .done(done[1]), .sram_ce_n(ce_n[1]),
      .sram_oe_n(oe_n[1]), .sram_we_n(we_n[1]), .sram_addr(sa[1]), .sram_dq_o(dq_o[1]),
      .sram_dq_oe(dq_oe[1]), .sram_dq_i(dq_i[1])
   );

   int checks = 0;
   int fails  = 0;

   // monitor counters, written only by the monitors below
   int smp     [2] = '{0, 0};
   int ce_cnt  [2] = '{0, 0};
   int we_cnt  [2] = '{0, 0};
   int drv_cnt [2] = '{0, 0};
   int done_cnt[2] = '{0, 0};
   int viol    [2] = '{0, 0};
   int ce_fall [2] = '{0, 0};
   int we_fall [2] = '{0, 0};

   for (genvar g = 0; g < 2; g++) begin : g_side
      logic [7:0] mem [256];
      logic       vld = 1'b0;
      logic       p_ce = 1'b1;
      logic       p_we = 1'b1;
      logic       p_drv = 1'b0;
      logic [7:0] p_addr = 8'h00;
      logic [7:0] p_dat = 8'h00;

      initial for (int k = 0; k < 256; k++) mem[k] = 8'h00;

      // RAM data appears just before its access time; 8'hEE marks "not yet valid"
      always begin
         @(negedge ce_n[g]);
         vld = 1'b0;
         #(ACC_NS[g] - 1);
         if (!ce_n[g]) begin
            vld = 1'b1;
            @(posedge ce_n[g]);
         end
         vld = 1'b0;
      end

      assign dq_i[g] = (!ce_n[g] && !oe_n[g] && we_n[g] && vld) ? mem[sa[g]] : 8'hEE;

      always @(posedge we_n[g])
         if (rst_n && !ce_n[g] && dq_oe[g]) mem[sa[g]] = dq_o[g];

      always @(negedge clk) begin
         smp[g] = smp[g] + 1;
         if (!ce_n[g]) ce_cnt[g] = ce_cnt[g] + 1;
         if (!we_n[g]) we_cnt[g] = we_cnt[g] + 1;
         if (dq_oe[g]) drv_cnt[g] = drv_cnt[g] + 1;
         if (done[g]) done_cnt[g] = done_cnt[g] + 1;
         if (!ce_n[g] && p_ce) ce_fall[g] = smp[g];
         if (!we_n[g] && p_we) we_fall[g] = smp[g];
         if (!we_n[g] && ce_n[g]) viol[g] = viol[g] + 1;                       // R2
         if (!oe_n[g] && !we_n[g]) viol[g] = viol[g] + 1;                      // R3
         if (dq_oe[g] && !oe_n[g]) viol[g] = viol[g] + 1;                      // R4
         if (!ce_n[g] && !p_ce && sa[g] != p_addr) viol[g] = viol[g] + 1;      // R11
         if (dq_oe[g] && p_drv && dq_o[g] != p_dat) viol[g] = viol[g] + 1;     // R7
         p_ce = ce_n[g]; p_we = we_n[g]; p_drv = dq_oe[g];
         p_addr = sa[g]; p_dat = dq_o[g];
      end
   end

   task automatic chk(input string rq, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic wait_done(input int i, input int target);
      while (done_cnt[i] < target) @(posedge clk);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      for (int i = 0; i < 2; i++) begin
         chk("R1 pins in reset", {ce_n[i], oe_n[i], we_n[i], dq_oe[i], done[i]}, 5'b11100);
      end
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      for (int i = 0; i < 2; i++) begin
         chk("R1 pins idle", {ce_n[i], oe_n[i], we_n[i], dq_oe[i], done[i]}, 5'b11100);
      end
   endtask

   task automatic t_write(input int i, input logic [7:0] a, input logic [7:0] d);
      int c0 = ce_cnt[i];
      int w0 = we_cnt[i];
      int v0 = drv_cnt[i];
      int d0 = done_cnt[i];
      logic [7:0] r0 = rd[i];
      @(posedge clk); #1;
      req[i] = 1'b1; wen[i] = 1'b1; ha[i] = a; hw[i] = d;
      @(posedge clk); #1;
      req[i] = 1'b0;
      wait_done(i, d0 + 1);
      repeat (2) @(posedge clk); #1;
      chk("R8 write select length", ce_cnt[i] - c0, EXP_WT[i]);
      chk("R6 write strobe length", we_cnt[i] - w0, EXP_WP[i]);
      chk("R6 strobe offset", we_fall[i] - ce_fall[i], EXP_AS[i]);
      chk("R7 drive window", drv_cnt[i] - v0, EXP_DRV[i]);
      chk("R9 one done per write", done_cnt[i] - d0, 1);
      chk("R5 rd_data kept over write", int'(rd[i]), int'(r0));
   endtask

   task automatic t_read(input int i, input logic [7:0] a, input logic [7:0] exp);
      int c0 = ce_cnt[i];
      int v0 = drv_cnt[i];
      int d0 = done_cnt[i];
      @(posedge clk); #1;
      req[i] = 1'b1; wen[i] = 1'b0; ha[i] = a;
      @(posedge clk); #1;
      req[i] = 1'b0;
      wait_done(i, d0 + 1);
      repeat (2) @(posedge clk); #1;
      chk("R5 read select length", ce_cnt[i] - c0, EXP_RD[i]);
      chk("R5 R7 read data", int'(rd[i]), int'(exp));
      chk("R4 no drive in read", drv_cnt[i] - v0, 0);
      chk("R9 one done per read", done_cnt[i] - d0, 1);
   endtask

   // R10: a request arriving mid-access is dropped
   task automatic t_busy_req(input int i);
      int c0 = ce_cnt[i];
      int d0 = done_cnt[i];
      @(posedge clk); #1;
      req[i] = 1'b1; wen[i] = 1'b1; ha[i] = 8'h30; hw[i] = 8'h5A;
      @(posedge clk); #1;
      req[i] = 1'b0;
      repeat (2) @(posedge clk); #1;
      req[i] = 1'b1; wen[i] = 1'b1; ha[i] = 8'h31; hw[i] = 8'h77;
      @(posedge clk); #1;
      req[i] = 1'b0;
      wait_done(i, d0 + 1);
      repeat (4) @(posedge clk); #1;
      chk("R10 busy request dropped (select)", ce_cnt[i] - c0, EXP_WT[i]);
      chk("R10 busy request dropped (done)", done_cnt[i] - d0, 1);
      t_read(i, 8'h31, 8'h00);
      t_read(i, 8'h30, 8'h5A);
   endtask

   // R10: request held through done is taken at the following edge
   task automatic t_back_to_back(input int i);
      int c0 = ce_cnt[i];
      int d0 = done_cnt[i];
      @(posedge clk); #1;
      req[i] = 1'b1; wen[i] = 1'b1; ha[i] = 8'h40; hw[i] = 8'hC3;
      @(posedge clk); #1;
      wen[i] = 1'b0;
      wait_done(i, d0 + 1);
      #1;
      req[i] = 1'b0;
      wait_done(i, d0 + 2);
      repeat (2) @(posedge clk); #1;
      chk("R10 chained done count", done_cnt[i] - d0, 2);
      chk("R10 chained select length", ce_cnt[i] - c0, EXP_WT[i] + EXP_RD[i]);
      chk("R10 chained read data", int'(rd[i]), 8'hC3);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", done_cnt[0], -1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      t_reset();
      for (int i = 0; i < 2; i++) begin
         t_write(i, 8'h05, 8'h11);
         t_write(i, 8'hFF, 8'hA5);
         t_write(i, 8'h00, 8'h3C);
         t_read(i, 8'h05, 8'h11);
         t_read(i, 8'hFF, 8'hA5);
         t_read(i, 8'h00, 8'h3C);
         t_read(i, 8'h80, 8'h00);
         t_write(i, 8'h05, 8'h96);
         t_read(i, 8'h05, 8'h96);
         t_busy_req(i);
         t_back_to_back(i);
         chk("R2 R3 R4 R7 R11 pin rules", viol[i], 0);
         chk("R1 idle after tests", {ce_n[i], oe_n[i], we_n[i], dq_oe[i]}, 4'b1110);
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule